// File: doc/BRIEF.md
# Crossbar Master Transaction Sequencer

This block is the master-side control engine for a crossbar transfer between a board's local FIFOs and a remote crossbar slave. A single go input starts it, and it runs in the crossbar data clock domain. First it runs the header: it asks board logic for a route word with a route strobe. It forwards that word to the crossbar, followed by a shifted copy of it. When the crossbar replies with a change-to-address code, it asks for an address word with an address strobe and forwards that word as well. It then waits for a data-strobe-enable reply.

Bit 1 of the captured address word selects one of two data phases. In a master write, words are pulled from the input FIFO one per cycle and registered onto the crossbar output bus. This continues until the input FIFO reports almost-empty. In a master read, the block requests transfers from the slave and registers each received word onto the FIFO bus with a write strobe. It withholds those requests while the output FIFO is almost full, and it finishes when the crossbar signals completion. A separate kill request warns a remote master when go is held high during a slave transaction.

The FIFO data bus is split into an input half, an output half and a drive-enable, so that the tri-state buffer lives outside the block.

Top module: `xbar_master_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every output is low: strobes, status, request, kill, and both valid/enable flags.
- R2: If go is sampled high at clock edge k in the idle state, route_req is low until edge k+2 and is high after edge k+2.
- R3: The route word on fifo_in is captured at the end of the first route_req cycle. The next cycle shows it on xb_out with xb_out_vld high, and master rises in that same cycle. The cycle after that shows the word shifted right by ROUTE_SHIFT bits, also with xb_out_vld high. xb_out_vld then goes low.
- R4: While waiting on the route phase, a reply code of 1 (change-to-address) on rsp drops route_req at the next edge. There is one cycle with both header strobes low, and then addr_req rises. route_req and addr_req are never high together.
- R5: The address word on fifo_in is captured at the end of the first addr_req cycle and is shown on xb_out with xb_out_vld high in the next cycle. addr_req stays high until a reply code of 2 (data-strobe-enable) is seen, and it drops at the next edge.
- R6: Bit 1 of the captured address word selects the data phase: 0 is a master write and 1 is a master read. in_re and out_we are never high together.
- R7: In a master write, every cycle with in_ae low raises in_re and in_oe. The fifo_in word of that cycle appears on xb_out with xb_out_vld high one cycle later. fifo_out_en stays low.
- R8: In a master write, a cycle with in_ae high raises neither in_re nor in_oe. The transaction ends at that edge, so master is low in the next cycle.
- R9: In a master read, a cycle with xb_in_vld high puts that xb_in word on fifo_out, with out_we high, in the next cycle. fifo_out_en is high throughout the read phase.
- R10: In a master read, xb_req is high exactly in the cycles where out_af is low. Requests resume as soon as out_af clears.
- R11: In a master read, a reply code of 3 (done) on rsp ends the transaction. In the next cycle master, xb_req and both header strobes are low.
- R12: After a transaction ends, the block stays idle (route_req and master low) until go is sampled high again.
- R13: kill_req is high in the cycle after an edge at which go and slave_busy were both high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossbar data clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Launches a master transaction when sampled high in idle |
| slave_busy | input | 1 | A slave transaction is in progress on this node |
| rsp | input | 2 | Crossbar reply code: 0 none, 1 change-to-address, 2 data-strobe-enable, 3 done |
| fifo_in | input | DW | FIFO data bus as seen by the block (header words, input FIFO data) |
| in_ae | input | 1 | Input FIFO almost-empty flag |
| out_af | input | 1 | Output FIFO almost-full flag |
| xb_in | input | DW | Word received from the crossbar |
| xb_in_vld | input | 1 | xb_in carries a valid word |
| route_req | output | 1 | Board logic must place the route word on the FIFO bus |
| addr_req | output | 1 | Board logic must place the address word on the FIFO bus |
| master | output | 1 | Master transaction in progress |
| kill_req | output | 1 | Kill request toward a remote master |
| in_re | output | 1 | Input FIFO read enable |
| in_oe | output | 1 | Input FIFO output enable |
| out_we | output | 1 | Output FIFO write enable |
| fifo_out | output | DW | Word driven onto the FIFO bus in a master read |
| fifo_out_en | output | 1 | Drive enable for fifo_out onto the FIFO bus |
| xb_out | output | DW | Word driven onto the crossbar |
| xb_out_vld | output | 1 | xb_out carries a valid word |
| xb_req | output | 1 | Transfer request to the crossbar slave |

## Verification
The assertions assume that the crossbar sends each reply only in the phase that waits for it. They also assume that the header words are present on fifo_in during the first cycle of their strobe. The bench keeps to this by driving rsp for exactly one cycle at the waiting point, and by setting the word at the negative edge that opens the strobe's first cycle. The bench models the slave as returning a word only in cycles where the request is high. It sweeps write lengths from zero to four words and every four-cycle almost-full pattern on reads.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM1,
        S_ARM2,
        S_RT_CAP,
        S_RT_SHF,
        S_RT_WAIT,
        S_GAP,
        S_AD_CAP,
        S_AD_WAIT,
        S_WR,
        S_RD
    } seq_state_t;

    localparam logic [1:0] RSP_NONE = 2'd0;
    localparam logic [1:0] RSP_CHG  = 2'd1;
    localparam logic [1:0] RSP_DSE  = 2'd2;
    localparam logic [1:0] RSP_DONE = 2'd3;

    // position of the direction flag inside the address word
    localparam int DIR_BIT = 1;

    function automatic logic is_header(input seq_state_t s);
        return (s == S_RT_CAP) || (s == S_RT_SHF) || (s == S_RT_WAIT);
    endfunction

    function automatic logic is_addr(input seq_state_t s);
        return (s == S_AD_CAP) || (s == S_AD_WAIT);
    endfunction

endpackage

// File: rtl/xbm_ctrl.sv
module xbm_ctrl
    import xbm_pkg::*;
#(
    parameter int DW        = 32,
    parameter int ROUTE_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [1:0]    rsp,
    input  logic [DW-1:0] fifo_in,
    input  logic          in_ae,
    output logic          route_req,
    output logic          addr_req,
    output logic          master,
    output logic          wr_active,
    output logic          rd_active,
    output logic [DW-1:0] hdr_out,
    output logic          hdr_vld
);

    seq_state_t st, st_nx;
    logic [DW-1:0] route_q;
    logic          dir_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (go) st_nx = S_ARM1;
            S_ARM1:    st_nx = S_ARM2;
            S_ARM2:    st_nx = S_RT_CAP;
            S_RT_CAP:  st_nx = S_RT_SHF;
            S_RT_SHF:  st_nx = S_RT_WAIT;
            S_RT_WAIT: if (rsp == RSP_CHG) st_nx = S_GAP;
            S_GAP:     st_nx = S_AD_CAP;
            S_AD_CAP:  st_nx = S_AD_WAIT;
            S_AD_WAIT: if (rsp == RSP_DSE) st_nx = dir_q ? S_RD : S_WR;
            S_WR:      if (in_ae) st_nx = S_IDLE;
            S_RD:      if (rsp == RSP_DONE) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            master  <= 1'b0;
            hdr_vld <= 1'b0;
            hdr_out <= '0;
            route_q <= '0;
            dir_q   <= 1'b0;
        end else begin
            st      <= st_nx;
            hdr_vld <= 1'b0;
            case (st)
                S_RT_CAP: begin
                    route_q <= fifo_in;
                    hdr_out <= fifo_in;
                    hdr_vld <= 1'b1;
                    master  <= 1'b1;
                end
                S_RT_SHF: begin
                    hdr_out <= route_q >> ROUTE_SHIFT;
                    hdr_vld <= 1'b1;
                end
                S_AD_CAP: begin
                    hdr_out <= fifo_in;
                    hdr_vld <= 1'b1;
                    dir_q   <= fifo_in[DIR_BIT];
                end
                default: ;
            endcase
            if (st_nx == S_IDLE) master <= 1'b0;
        end
    end

    assign route_req = is_header(st);
    assign addr_req  = is_addr(st);
    assign wr_active = (st == S_WR);
    assign rd_active = (st == S_RD);

    AST_ROUTE_DELAY: assert property (@(posedge clk) disable iff (rst)
        $rose(route_req) |-> $past(go, 3)); // R2
    AST_ROUTE_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(route_req) |-> $past(rsp) == RSP_CHG); // R4
    AST_ADDR_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_req) |-> (!$past(route_req) && $past(route_req, 2))); // R4
    AST_ADDR_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_req) |-> $past(rsp) == RSP_DSE); // R5
    AST_MASTER_HDR: assert property (@(posedge clk) disable iff (rst)
        $rose(master) |-> hdr_vld); // R3

endmodule

// File: rtl/xbm_wpath.sv
module xbm_wpath #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          in_ae,
    input  logic [DW-1:0] fifo_in,
    output logic          in_re,
    output logic          in_oe,
    output logic [DW-1:0] wdat,
    output logic          wvld
);

    logic pull;
    assign pull  = active && !in_ae;
    assign in_re = pull;
    assign in_oe = pull;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdat <= '0;
            wvld <= 1'b0;
        end else begin
            wvld <= pull;
            if (pull) wdat <= fifo_in;
        end
    end

    AST_WVLD_AFTER_PULL: assert property (@(posedge clk) disable iff (rst)
        wvld |-> $past(in_re)); // R7

endmodule

// File: rtl/xbm_rpath.sv
module xbm_rpath #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          out_af,
    input  logic [DW-1:0] xb_in,
    input  logic          xb_in_vld,
    output logic          xb_req,
    output logic [DW-1:0] fifo_out,
    output logic          out_we,
    output logic          fifo_out_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_out <= '0;
            out_we   <= 1'b0;
        end else begin
            out_we <= active && xb_in_vld;
            if (active && xb_in_vld) fifo_out <= xb_in;
        end
    end

    assign xb_req      = active && !out_af;
    assign fifo_out_en = active || out_we;

    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        out_we |-> fifo_out_en); // R9

endmodule

// File: rtl/xbar_master_seq.sv
module xbar_master_seq
    import xbm_pkg::*;
#(
    parameter int DW          = 32,
    parameter int ROUTE_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          slave_busy,
    input  logic [1:0]    rsp,
    input  logic [DW-1:0] fifo_in,
    input  logic          in_ae,
    input  logic          out_af,
    input  logic [DW-1:0] xb_in,
    input  logic          xb_in_vld,
    output logic          route_req,
    output logic          addr_req,
    output logic          master,
    output logic          kill_req,
    output logic          in_re,
    output logic          in_oe,
    output logic          out_we,
    output logic [DW-1:0] fifo_out,
    output logic          fifo_out_en,
    output logic [DW-1:0] xb_out,
    output logic          xb_out_vld,
    output logic          xb_req
);

    logic          wr_active, rd_active;
    logic [DW-1:0] hdr_out, wdat;
    logic          hdr_vld, wvld;

    xbm_ctrl #(.DW(DW), .ROUTE_SHIFT(ROUTE_SHIFT)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .rsp       (rsp),
        .fifo_in   (fifo_in),
        .in_ae     (in_ae),
        .route_req (route_req),
        .addr_req  (addr_req),
        .master    (master),
        .wr_active (wr_active),
        .rd_active (rd_active),
        .hdr_out   (hdr_out),
        .hdr_vld   (hdr_vld)
    );

    xbm_wpath #(.DW(DW)) u_wpath (
        .clk     (clk),
        .rst     (rst),
        .active  (wr_active),
        .in_ae   (in_ae),
        .fifo_in (fifo_in),
        .in_re   (in_re),
        .in_oe   (in_oe),
        .wdat    (wdat),
        .wvld    (wvld)
    );

    xbm_rpath #(.DW(DW)) u_rpath (
        .clk         (clk),
        .rst         (rst),
        .active      (rd_active),
        .out_af      (out_af),
        .xb_in       (xb_in),
        .xb_in_vld   (xb_in_vld),
        .xb_req      (xb_req),
        .fifo_out    (fifo_out),
        .out_we      (out_we),
        .fifo_out_en (fifo_out_en)
    );

    // header words and write data never overlap in time
    assign xb_out     = hdr_vld ? hdr_out : wdat;
    assign xb_out_vld = hdr_vld || wvld;

    always_ff @(posedge clk) begin
        if (rst) kill_req <= 1'b0;
        else     kill_req <= go && slave_busy;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_re && out_we)); // R6
    AST_HDR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(route_req && addr_req)); // R4
    AST_WR_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
        in_re |-> !fifo_out_en); // R7
    AST_DATA_IN_TXN: assert property (@(posedge clk) disable iff (rst)
        (in_re || xb_req) |-> master); // R11
    AST_KILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        kill_req |-> ($past(go) && $past(slave_busy))); // R13

endmodule

// File: tb/sim_xbar_master_seq.sv
module sim_xbar_master_seq;

    localparam int DW  = 32;
    localparam int RSH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0, slave_busy = 1'b0;
    logic [1:0]    rsp = 2'd0;
    logic [DW-1:0] fifo_in = '0, xb_in = '0;
    logic          in_ae = 1'b0, out_af = 1'b0, xb_in_vld = 1'b0;
    logic          route_req, addr_req, master, kill_req;
    logic          in_re, in_oe, out_we, fifo_out_en, xb_out_vld, xb_req;
    logic [DW-1:0] fifo_out, xb_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    xbar_master_seq #(.DW(DW), .ROUTE_SHIFT(RSH)) u0 (
        .clk(clk), .rst(rst), .go(go), .slave_busy(slave_busy), .rsp(rsp),
        .fifo_in(fifo_in), .in_ae(in_ae), .out_af(out_af), .xb_in(xb_in),
        .xb_in_vld(xb_in_vld), .route_req(route_req), .addr_req(addr_req),
        .master(master), .kill_req(kill_req), .in_re(in_re), .in_oe(in_oe),
        .out_we(out_we), .fifo_out(fifo_out), .fifo_out_en(fifo_out_en),
        .xb_out(xb_out), .xb_out_vld(xb_out_vld), .xb_req(xb_req)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [9:0] outs();
        return {route_req, addr_req, master, kill_req, in_re, in_oe, out_we,
                fifo_out_en, xb_out_vld, xb_req};
    endfunction

    // header sequence; returns with the block in its data phase
    task automatic run_header(input logic [DW-1:0] rw, input logic [DW-1:0] aw);
        go = 1'b1; #1;
        chk(route_req == 1'b0, "R2", route_req, 0);
        tick(); go = 1'b0; #1;
        chk(route_req == 1'b0, "R2", route_req, 0);
        chk(kill_req == 1'b0, "R13", kill_req, 0);
        tick();
        chk(route_req == 1'b0, "R2", route_req, 0);
        tick();
        chk(route_req == 1'b1, "R2", route_req, 1);
        chk(master == 1'b0, "R3", master, 0);
        fifo_in = rw;
        tick(); fifo_in = '0;
        chk(xb_out_vld && xb_out == rw, "R3", xb_out, rw);
        chk(master == 1'b1, "R3", master, 1);
        tick();
        chk(xb_out_vld && xb_out == (rw >> RSH), "R3", xb_out, rw >> RSH);
        tick();
        chk(xb_out_vld == 1'b0, "R3", xb_out_vld, 0);
        chk(route_req == 1'b1, "R4", route_req, 1);
        rsp = 2'd1;
        tick(); rsp = 2'd0;
        chk(!route_req && !addr_req, "R4", {route_req, addr_req}, 0);
        tick();
        chk(addr_req == 1'b1 && !route_req, "R4", {route_req, addr_req}, 1);
        fifo_in = aw;
        tick(); fifo_in = '0;
        chk(xb_out_vld && xb_out == aw, "R5", xb_out, aw);
        tick();
        chk(addr_req && !xb_out_vld, "R5", {addr_req, xb_out_vld}, 2);
        rsp = 2'd2;
        tick(); rsp = 2'd0;
        chk(addr_req == 1'b0, "R5", addr_req, 0);
    endtask

    task automatic run_write(input int n, input logic [DW-1:0] seed);
        logic [DW-1:0] prev = '0;
        run_header(seed, (seed << 4) & ~32'h2);
        for (int j = 0; j <= n; j++) begin
            if (j > 0) chk(xb_out_vld && xb_out == prev, "R7", xb_out, prev);
            in_ae = (j == n);
            fifo_in = seed + 32'h0101_0101 * j;
            #1;
            if (j < n) begin
                chk(in_re && in_oe && !fifo_out_en, "R7", {in_re, in_oe, fifo_out_en}, 6);
                chk(out_we == 1'b0 && xb_req == 1'b0, "R6", {out_we, xb_req}, 0);
            end else begin
                chk(!in_re && !in_oe, "R8", {in_re, in_oe}, 0);
            end
            prev = fifo_in;
            tick();
        end
        in_ae = 1'b0; fifo_in = '0;
        chk(master == 1'b0 && xb_out_vld == 1'b0, "R8", {master, xb_out_vld}, 0);
    endtask

    task automatic run_read(input logic [3:0] mask, input logic [DW-1:0] seed);
        logic          sent = 1'b0;
        logic [DW-1:0] prev = '0;
        run_header(seed ^ 32'hA5A5_0000, (seed << 4) | 32'h2);
        for (int j = 0; j <= 4; j++) begin
            if (sent) chk(out_we && fifo_out == prev, "R9", fifo_out, prev);
            else      chk(out_we == 1'b0, "R9", out_we, 0);
            chk(fifo_out_en == 1'b1, "R9", fifo_out_en, 1);
            if (j < 4) begin
                out_af = mask[j];
                #1;
                chk(xb_req == !mask[j], "R10", xb_req, !mask[j]);
                chk(in_re == 1'b0, "R6", in_re, 0);
                xb_in_vld = xb_req;
                xb_in = seed * (j + 3);
                sent = xb_req;
                prev = xb_in;
            end else begin
                out_af = 1'b0; xb_in_vld = 1'b0;
                rsp = 2'd3;
            end
            tick();
        end
        rsp = 2'd0; xb_in_vld = 1'b0;
        #1;
        chk(!master && !xb_req && !route_req && !addr_req, "R11",
            {master, xb_req, route_req, addr_req}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : main
        tick(); tick();
        chk(outs() == 10'd0, "R1", outs(), 0);
        go = 1'b1; slave_busy = 1'b1;
        tick();
        chk(outs() == 10'd0, "R1", outs(), 0);
        go = 1'b0; slave_busy = 1'b0;
        rst = 1'b0;
        tick();
        chk(outs() == 10'd0, "R1", outs(), 0);

        for (int n = 0; n <= 4; n++) begin
            run_write(n, 32'h1357_9BDF + n * 32'h0011_0000);
            for (int k = 0; k < 3; k++) begin
                tick();
                chk(!route_req && !master, "R12", {route_req, master}, 0);
            end
        end
        for (int m = 0; m < 16; m++) begin
            run_read(m[3:0], 32'h0F0F_3C3C ^ (m * 32'h0101_0011));
            tick();
            chk(!route_req && !master, "R12", {route_req, master}, 0);
        end

        // kill request
        slave_busy = 1'b1;
        tick();
        chk(kill_req == 1'b0, "R13", kill_req, 0);
        go = 1'b1;
        tick(); go = 1'b0;
        chk(kill_req == 1'b1, "R13", kill_req, 1);
        tick();
        chk(kill_req == 1'b0, "R13", kill_req, 0);
        slave_busy = 1'b0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk(outs() == 10'd0, "R1", outs(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule